// File: doc/BRIEF.md
# Four-Read Two-Write Bypassed Floating-Point Register File

This block stores the floating-point operands of a processor core: 32 registers, each 64 bits wide. The ports are split by the kind of traffic they carry. The fused multiply-add pipe has three read ports, one for each of its three source operands, and one write port for its results. The memory path has one read port that feeds stores and one write port that receives load data. Because the two groups of ports are separate, a 64-bit load or store can use the file on every cycle while arithmetic runs alongside it.

Reads are combinational. Each read port takes the value from the storage array, unless a write port is writing the same register in that cycle. In that case the read port returns the incoming data. Writes are committed on the rising clock edge. When both write ports target the same register in one cycle, the memory-path write is the one that lands. The bypass logic follows the same rule, so a read always returns the value that gets committed. The output `wr_collide` is raised in every cycle where the two writes collide.

Top module: `fpreg_file4r2w`

## Requirements
- R1: While `rst_n` is low, all 32 entries are cleared. After reset, every register reads as zero on every read port until it is written.
- R2: A write on the arithmetic port (`mac_we` = 1) commits `mac_wdata` to register `mac_waddr` at the rising edge. After that edge, every read port that addresses that register returns the new data.
- R3: A write on the memory port (`mem_we` = 1) commits `mem_wdata` to register `mem_waddr` at the rising edge. After that edge, every read port that addresses that register returns the new data.
- R4: In a cycle where the arithmetic port writes register N and the memory port does not write N, every read port addressing N returns `mac_wdata` in that same cycle.
- R5: In a cycle where the memory port writes register N, every read port addressing N returns `mem_wdata` in that same cycle.
- R6: When both write ports are enabled with the same address, the register holds `mem_wdata` after the edge.
- R7: During such a collision, every read port addressing the shared register returns `mem_wdata`, never `mac_wdata`.
- R8: `wr_collide` is 1 exactly when `mac_we` and `mem_we` are both 1 and `mac_waddr` equals `mem_waddr`. Otherwise it is 0.
- R9: When both write ports are enabled with different addresses, both registers are updated at the same edge.
- R10: A write port with its enable at 0 changes no register and bypasses nothing, whatever its address and data inputs hold.
- R11: With no write to the addressed register, each of the four read ports independently returns that register's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the array |
| mac_we | input | 1 | Write enable, arithmetic result port |
| mac_waddr | input | 5 | Write register index, arithmetic port |
| mac_wdata | input | 64 | Write data, arithmetic port |
| mem_we | input | 1 | Write enable, load data port |
| mem_waddr | input | 5 | Write register index, load port |
| mem_wdata | input | 64 | Write data, load port |
| src_a_addr | input | 5 | Read index, first multiply-add operand |
| src_b_addr | input | 5 | Read index, second multiply-add operand |
| src_c_addr | input | 5 | Read index, addend operand |
| st_addr | input | 5 | Read index, store data port |
| src_a_data | output | 64 | Read data, first operand |
| src_b_data | output | 64 | Read data, second operand |
| src_c_data | output | 64 | Read data, addend |
| st_data | output | 64 | Read data for stores |
| wr_collide | output | 1 | Both write ports hit the same register this cycle |

## Verification
The bench aims at three corner cases.

- **Same-cycle bypass.** Directed steps read a register on all four ports in the cycle it is written, once through each write port. A design without the bypass would return the old contents.
- **Write collision.** Collisions are forced both directed and through a narrowed random address range. A design with the priority reversed would either commit the arithmetic data or bypass it, disagreeing with the stored result in the next cycle.
- **Idle write ports.** A disabled port is driven with live-looking address and data. A design that ignored the enable would corrupt the register or bypass stale data.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    // Where a read port takes its data from in the current cycle
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_MAC   = 2'd1,
        SRC_MEM   = 2'd2
    } byp_src_e;

    // The load/store write outranks the arithmetic write, matching commit order
    function automatic byp_src_e pick_src(input logic mac_hit, input logic mem_hit);
        if (mem_hit)      return SRC_MEM;
        else if (mac_hit) return SRC_MAC;
        else              return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/fprf_store.sv
module fprf_store #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mac_we,
    input  logic [AW-1:0]           mac_waddr,
    input  logic [DW-1:0]           mac_wdata,
    input  logic                    mem_we,
    input  logic [AW-1:0]           mem_waddr,
    input  logic [DW-1:0]           mem_wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rarr
);

    logic [DW-1:0] regs [NREG];

    // The memory-port assignment comes last so it wins on a shared index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (mac_we) regs[mac_waddr] <= mac_wdata;
            if (mem_we) regs[mem_waddr] <= mem_wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rarr[p] = regs[raddr[p]];
    end

    AST_MEM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && mem_we && mac_waddr == mem_waddr) |=> regs[$past(mem_waddr)] == $past(mem_wdata)); // R6
    AST_MAC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && !(mem_we && mem_waddr == mac_waddr)) |=> regs[$past(mac_waddr)] == $past(mac_wdata)); // R2
    AST_MEM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> regs[$past(mem_waddr)] == $past(mem_wdata)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_we && !mem_we && $past(rst_n)) |=> regs[$past(raddr[0])] == $past(rarr[0])); // R10

endmodule

// File: rtl/fprf_bypass.sv
module fprf_bypass
    import fprf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  raddr,
    input  logic [DW-1:0]  arr_data,
    input  logic           mac_we,
    input  logic [AW-1:0]  mac_waddr,
    input  logic [DW-1:0]  mac_wdata,
    input  logic           mem_we,
    input  logic [AW-1:0]  mem_waddr,
    input  logic [DW-1:0]  mem_wdata,
    output logic [DW-1:0]  rdata
);

    logic     mac_hit, mem_hit;
    byp_src_e src;

    assign mac_hit = mac_we && (mac_waddr == raddr);
    assign mem_hit = mem_we && (mem_waddr == raddr);
    assign src     = pick_src(mac_hit, mem_hit);

    always_comb begin
        unique case (src)
            SRC_MEM: rdata = mem_wdata;
            SRC_MAC: rdata = mac_wdata;
            default: rdata = arr_data;
        endcase
    end

    AST_BYP_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr == raddr) |-> rdata == mem_wdata); // R5
    AST_BYP_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && mac_waddr == raddr && !(mem_we && mem_waddr == raddr)) |-> rdata == mac_wdata); // R4
    AST_NO_BYP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mac_we && mac_waddr == raddr) && !(mem_we && mem_waddr == raddr)) |-> rdata == arr_data); // R11

endmodule

// File: rtl/fpreg_file4r2w.sv
module fpreg_file4r2w #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG),
    localparam int NRD = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mac_we,
    input  logic [AW-1:0]  mac_waddr,
    input  logic [DW-1:0]  mac_wdata,
    input  logic           mem_we,
    input  logic [AW-1:0]  mem_waddr,
    input  logic [DW-1:0]  mem_wdata,
    input  logic [AW-1:0]  src_a_addr,
    input  logic [AW-1:0]  src_b_addr,
    input  logic [AW-1:0]  src_c_addr,
    input  logic [AW-1:0]  st_addr,
    output logic [DW-1:0]  src_a_data,
    output logic [DW-1:0]  src_b_data,
    output logic [DW-1:0]  src_c_data,
    output logic [DW-1:0]  st_data,
    output logic           wr_collide
);

    logic [NRD-1:0][AW-1:0] raddr;
    logic [NRD-1:0][DW-1:0] rarr;
    logic [NRD-1:0][DW-1:0] rdata;

    // Ports 0..2 belong to the multiply-add pipe, port 3 to the store path
    assign raddr[0] = src_a_addr;
    assign raddr[1] = src_b_addr;
    assign raddr[2] = src_c_addr;
    assign raddr[3] = st_addr;

    fprf_store #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mac_we    (mac_we),
        .mac_waddr (mac_waddr),
        .mac_wdata (mac_wdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .raddr     (raddr),
        .rarr      (rarr)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        fprf_bypass #(.NREG(NREG), .DW(DW)) u_byp (
            .clk       (clk),
            .rst_n     (rst_n),
            .raddr     (raddr[p]),
            .arr_data  (rarr[p]),
            .mac_we    (mac_we),
            .mac_waddr (mac_waddr),
            .mac_wdata (mac_wdata),
            .mem_we    (mem_we),
            .mem_waddr (mem_waddr),
            .mem_wdata (mem_wdata),
            .rdata     (rdata[p])
        );
    end

    assign src_a_data = rdata[0];
    assign src_b_data = rdata[1];
    assign src_c_data = rdata[2];
    assign st_data    = rdata[3];

    assign wr_collide = mac_we && mem_we && (mac_waddr == mem_waddr);

    AST_COLLIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_collide && st_addr == mem_waddr) |-> st_data == mem_wdata); // R7

endmodule

// File: tb/sim_fpreg_file4r2w.sv
module sim_fpreg_file4r2w;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mac_we, mem_we;
    logic [4:0]  mac_waddr, mem_waddr;
    logic [63:0] mac_wdata, mem_wdata;
    logic [4:0]  ra [4];
    logic [63:0] rd [4];
    logic        wr_collide;

    logic [63:0] model [32];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fpreg_file4r2w u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mac_we     (mac_we),
        .mac_waddr  (mac_waddr),
        .mac_wdata  (mac_wdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .src_a_addr (ra[0]),
        .src_b_addr (ra[1]),
        .src_c_addr (ra[2]),
        .st_addr    (ra[3]),
        .src_a_data (rd[0]),
        .src_b_data (rd[1]),
        .src_c_data (rd[2]),
        .st_data    (rd[3]),
        .wr_collide (wr_collide)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_read(input logic [4:0] a);
        if (mem_we && mem_waddr == a)      return mem_wdata;
        else if (mac_we && mac_waddr == a) return mac_wdata;
        else                               return model[a];
    endfunction

    task automatic step(input logic awe, input logic [4:0] awa, input logic [63:0] awd,
                        input logic lwe, input logic [4:0] lwa, input logic [63:0] lwd,
                        input logic [4:0] r0, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [4:0] r3,
                        input string plain_tag);
        string t;
        @(negedge clk);
        mac_we = awe; mac_waddr = awa; mac_wdata = awd;
        mem_we = lwe; mem_waddr = lwa; mem_wdata = lwd;
        ra[0] = r0; ra[1] = r1; ra[2] = r2; ra[3] = r3;
        #1;
        for (int p = 0; p < 4; p++) begin
            logic mh, lh;
            mh = mac_we && mac_waddr == ra[p];
            lh = mem_we && mem_waddr == ra[p];
            t = (mh && lh) ? "R7" : lh ? "R5" : mh ? "R4" : plain_tag;
            chk(t, rd[p], exp_read(ra[p]));
        end
        chk("R8", {63'd0, wr_collide},
            {63'd0, mac_we && mem_we && mac_waddr == mem_waddr});
        @(posedge clk);
        if (mac_we) model[mac_waddr] = mac_wdata;
        if (mem_we) model[mem_waddr] = mem_wdata;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) model[i] = '0;
        rst_n = 1'b0;
        mac_we = 0; mem_we = 0; mac_waddr = 0; mem_waddr = 0;
        mac_wdata = 0; mem_wdata = 0;
        for (int p = 0; p < 4; p++) ra[p] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry is zero after reset, read through all four ports
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, 0, 0, 0, 5'(4*i), 5'(4*i+1), 5'(4*i+2), 5'(4*i+3), "R1");

        // R4 then R2: arithmetic write bypassed, then read from the array
        step(1, 5'd3, 64'hA5A5_0000_1111_2222, 0, 0, 0, 3, 3, 3, 3, "R11");
        step(0, 0, 0, 0, 0, 0, 3, 3, 3, 3, "R2");
        // R5 then R3: load write bypassed, then stored
        step(0, 0, 0, 1, 5'd17, 64'hDEAD_BEEF_CAFE_F00D, 17, 17, 17, 17, "R11");
        step(0, 0, 0, 0, 0, 0, 17, 17, 17, 17, "R3");
        // R7 then R6: collision on register 9, load data must win
        step(1, 5'd9, 64'h1111_1111_1111_1111, 1, 5'd9, 64'h2222_2222_2222_2222, 9, 9, 9, 9, "R11");
        step(0, 0, 0, 0, 0, 0, 9, 9, 9, 9, "R6");
        // R9: two different registers written together
        step(1, 5'd30, 64'h3030_3030_3030_3030, 1, 5'd31, 64'h3131_3131_3131_3131, 0, 1, 2, 4, "R11");
        step(0, 0, 0, 0, 0, 0, 30, 31, 30, 31, "R9");
        // R10: disabled ports with live-looking address/data
        step(0, 5'd9, 64'hBAD0_BAD0_BAD0_BAD0, 0, 5'd17, 64'hBAD1_BAD1_BAD1_BAD1, 9, 17, 9, 17, "R10");
        step(0, 0, 0, 0, 0, 0, 9, 17, 9, 17, "R10");
        // R11: four ports each reading a different register
        step(0, 0, 0, 0, 0, 0, 3, 17, 9, 31, "R11");

        // Random traffic, half of it squeezed into four registers to force hits
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] m;
            m = ($urandom % 2 == 0) ? 5'd3 : 5'd31;
            step(1'($urandom), 5'($urandom) & m, {$urandom, $urandom},
                 1'($urandom), 5'($urandom) & m, {$urandom, $urandom},
                 5'($urandom) & m, 5'($urandom) & m, 5'($urandom) & m, 5'($urandom) & m,
                 "R11");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule